// File: doc/BRIEF.md
# Per-Processor Interrupt Pending Register

This block is the local interrupt register of a single processor. It combines four request sources into one vector with one bit per priority level, for levels 1 to 15. The sources are software interrupts that the processor raises and clears itself, the processor's own timer line, a level-15 line that reaches every processor, and the hard interrupt levels that a master controller routes to this processor. Level 0 does not exist, so bit 0 of the output vector is always zero.

Software reaches the block through a 32-bit register port with zero wait states. A read of word offset 0 returns the pending word. A write to word offset 1 clears bits. A write to word offset 2 sets software bits. The pending word packs the sources as follows. Software requests sit in bits 31..17, and bit k asks for level k-16. Bit 16 always reads as zero. Bit 15 holds the level-15 request and bit 14 holds the timer request. The routed hard levels show up at the bit position equal to their level.

The timer and level-15 requests skip the per-source masking that the master controller applies. Only the global master-disable input can block them. The level vector is a register, so it changes one clock after the write or input change that causes it.

Top module: `cpuirq_pending_reg`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the pending word reads 0x00000000 and the level output is 0x0000.
- R2: A read (valid high, write low) of word offset 0 returns the pending word in the same cycle. A read of offset 1, 2 or 3 returns 0. While no read is in progress, rdata is 0.
- R3: A write to offset 1 clears each pending bit in 31..17, and bit 15, for which the write data has a 1. Bit 14, bit 16 and the hard-level bits are unaffected.
- R4: A write to offset 2 sets each pending bit in 31..17 for which the write data has a 1. Data bits 16..0 set nothing.
- R5: Pending bit 14 equals the timer input as sampled at the previous clock edge. Pending bit 15 is set at the first edge where the level-15 input is seen high after being low, and cleared at the first edge where it is seen low after being high.
- R6: Each pending software bit k (31..17) drives level output bit k-16.
- R7: Pending bits 14 and 15 drive level output bits 14 and 15 only while master-disable is 0. While master-disable is 1 they stay pending but do not reach the output.
- R8: Routed hard-level input bit n (1..15) appears at pending bit n and at level output bit n one clock later, whatever master-disable is. Hard input bit 0 is ignored.
- R9: Level output bit 0 is always 0.
- R10: The level output is registered. After a write or an input change it keeps its old value until the next clock edge, and then shows the new value.
- R11: A write to offset 0 or offset 3 changes neither the pending word nor the level output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access strobe, one cycle per access |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 2 | Word offset: 0 pending, 1 clear, 2 set, 3 reserved |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid in the cycle of the read |
| hard_lvl | input | 16 | Hard levels routed from the master controller, one bit per level |
| timer_req | input | 1 | Local timer request line |
| l15_req | input | 1 | Broadcast level-15 request line |
| master_dis | input | 1 | Global disable for the timer and level-15 requests |
| lvl_out | output | 16 | Per-level request vector, bit 0 always zero |

## Verification
The bench writes all-ones to the set and clear offsets. A mask that is off by one bit would then leave bit 16, bit 15 or bit 14 set, or leave level 1 stuck. It clears bit 15 in the same write that raises the timer, which catches a clear that can also erase the timer bit. It raises master-disable while the timer and a hard level 14 are both active: a design that gates the hard levels as well drops level 14, and one that ignores the flag keeps the timer on the output. It samples the level output both before and after the edge that follows a change, so a combinational output or a two-stage pipeline is caught. It also checks that a hard input bit 0 never reaches either output.

// File: rtl/cpuirq_pkg.sv
package cpuirq_pkg;

   // Word offsets of the register port; the processor decodes these.
   typedef enum logic [1:0] {
      OFS_PEND = 2'd0,
      OFS_CLR  = 2'd1,
      OFS_SET  = 2'd2,
      OFS_RSVD = 2'd3
   } cpuirq_ofs_e;

   localparam int unsigned ADDR_W = 2;

   // Mask of the software field (upper half minus its lowest bit).
   function automatic logic [63:0] soft_mask(input int unsigned lvl_n);
      logic [63:0] m;
      m = '0;
      for (int unsigned i = lvl_n + 1; i < 2 * lvl_n; i++) m[i] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/cpuirq_access_decode.sv
module cpuirq_access_decode
   import cpuirq_pkg::*;
#(
   parameter int unsigned LVL_N = 16,
   localparam int unsigned DW = 2 * LVL_N
) (
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DW-1:0]     acc_wdata,
   input  logic [DW-1:0]     pend_view,
   output logic              clr_en,
   output logic              set_en,
   output logic [DW-1:0]     clr_bits,
   output logic [DW-1:0]     set_bits,
   output logic [DW-1:0]     acc_rdata
);

   localparam logic [63:0] SOFT64 = soft_mask(LVL_N);
   localparam logic [DW-1:0] SET_MASK = SOFT64[DW-1:0];
   localparam logic [DW-1:0] CLR_MASK = SET_MASK | (DW'(1) << (LVL_N - 1));

   cpuirq_ofs_e ofs;
   logic        rd_hit;

   always_comb begin
      ofs      = cpuirq_ofs_e'(acc_addr);
      clr_en   = acc_valid && acc_write && (ofs == OFS_CLR);
      set_en   = acc_valid && acc_write && (ofs == OFS_SET);
      rd_hit   = acc_valid && !acc_write && (ofs == OFS_PEND);
      clr_bits = acc_wdata & CLR_MASK;
      set_bits = acc_wdata & SET_MASK;
      acc_rdata = rd_hit ? pend_view : '0;
   end

endmodule

// File: rtl/cpuirq_pend_store.sv
module cpuirq_pend_store #(
   parameter int unsigned LVL_N = 16,
   localparam int unsigned DW = 2 * LVL_N,
   localparam int unsigned SW = LVL_N - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_en,
   input  logic             set_en,
   input  logic [DW-1:0]    clr_bits,
   input  logic [DW-1:0]    set_bits,
   input  logic [LVL_N-1:0] hard_lvl,
   input  logic             timer_req,
   input  logic             l15_req,
   output logic [SW-1:0]    soft_nxt,
   output logic             top_nxt,
   output logic             tmr_nxt,
   output logic [LVL_N-1:0] hard_nxt,
   output logic [DW-1:0]    pend_view
);

   logic [SW-1:0]    soft_q;
   logic             top_q;
   logic             tmr_q;
   logic             l15_seen_q;
   logic [LVL_N-1:0] hard_q;

   always_comb begin
      soft_nxt = soft_q;
      if (clr_en) soft_nxt = soft_nxt & ~clr_bits[DW-1:LVL_N+1];
      if (set_en) soft_nxt = soft_nxt | set_bits[DW-1:LVL_N+1];

      top_nxt = top_q;
      if (clr_en && clr_bits[LVL_N-1]) top_nxt = 1'b0;
      // A line edge wins over a clear in the same cycle.
      if (l15_req && !l15_seen_q) top_nxt = 1'b1;
      if (!l15_req && l15_seen_q) top_nxt = 1'b0;

      tmr_nxt  = timer_req;
      hard_nxt = {hard_lvl[LVL_N-1:1], 1'b0};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         soft_q     <= '0;
         top_q      <= 1'b0;
         tmr_q      <= 1'b0;
         l15_seen_q <= 1'b0;
         hard_q     <= '0;
      end else begin
         soft_q     <= soft_nxt;
         top_q      <= top_nxt;
         tmr_q      <= tmr_nxt;
         l15_seen_q <= l15_req;
         hard_q     <= hard_nxt;
      end
   end

   always_comb begin
      pend_view = {soft_q, 1'b0, top_q, tmr_q, {(LVL_N-2){1'b0}}}
                | {{LVL_N{1'b0}}, hard_q};
   end

endmodule

// File: rtl/cpuirq_level_merge.sv
module cpuirq_level_merge #(
   parameter int unsigned LVL_N = 16,
   localparam int unsigned SW = LVL_N - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SW-1:0]    soft_nxt,
   input  logic             top_nxt,
   input  logic             tmr_nxt,
   input  logic [LVL_N-1:0] hard_nxt,
   input  logic             master_dis,
   output logic [LVL_N-1:0] lvl_out
);

   logic [LVL_N-1:1] lvl_d;
   logic [LVL_N-1:1] lvl_q;
   logic             bypass_ok;

   assign bypass_ok = !master_dis;

   for (genvar lv = 1; lv < LVL_N; lv++) begin : g_lvl
      if (lv == LVL_N - 1) begin : g_top
         assign lvl_d[lv] = soft_nxt[lv-1] | hard_nxt[lv] | (top_nxt & bypass_ok);
      end else if (lv == LVL_N - 2) begin : g_tmr
         assign lvl_d[lv] = soft_nxt[lv-1] | hard_nxt[lv] | (tmr_nxt & bypass_ok);
      end else begin : g_plain
         assign lvl_d[lv] = soft_nxt[lv-1] | hard_nxt[lv];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl_d;
   end

   assign lvl_out = {lvl_q, 1'b0};

endmodule

// File: rtl/cpuirq_pending_reg.sv
module cpuirq_pending_reg
   import cpuirq_pkg::*;
#(
   parameter int unsigned LVL_N = 16,
   localparam int unsigned DW = 2 * LVL_N,
   localparam int unsigned SW = LVL_N - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DW-1:0]     acc_wdata,
   output logic [DW-1:0]     acc_rdata,
   input  logic [LVL_N-1:0]  hard_lvl,
   input  logic              timer_req,
   input  logic              l15_req,
   input  logic              master_dis,
   output logic [LVL_N-1:0]  lvl_out
);

   if (LVL_N < 4 || LVL_N > 32) begin : g_bad_lvl_n
      $error("cpuirq_pending_reg: LVL_N must lie in 4..32");
   end

   logic          clr_en, set_en;
   logic [DW-1:0] clr_bits, set_bits, pend_view;
   logic [SW-1:0] soft_nxt;
   logic          top_nxt, tmr_nxt;
   logic [LVL_N-1:0] hard_nxt;

   cpuirq_access_decode #(.LVL_N(LVL_N)) u_dec (
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_addr  (acc_addr),
      .acc_wdata (acc_wdata),
      .pend_view (pend_view),
      .clr_en    (clr_en),
      .set_en    (set_en),
      .clr_bits  (clr_bits),
      .set_bits  (set_bits),
      .acc_rdata (acc_rdata)
   );

   cpuirq_pend_store #(.LVL_N(LVL_N)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_en    (clr_en),
      .set_en    (set_en),
      .clr_bits  (clr_bits),
      .set_bits  (set_bits),
      .hard_lvl  (hard_lvl),
      .timer_req (timer_req),
      .l15_req   (l15_req),
      .soft_nxt  (soft_nxt),
      .top_nxt   (top_nxt),
      .tmr_nxt   (tmr_nxt),
      .hard_nxt  (hard_nxt),
      .pend_view (pend_view)
   );

   cpuirq_level_merge #(.LVL_N(LVL_N)) u_merge (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_nxt   (soft_nxt),
      .top_nxt    (top_nxt),
      .tmr_nxt    (tmr_nxt),
      .hard_nxt   (hard_nxt),
      .master_dis (master_dis),
      .lvl_out    (lvl_out)
   );

endmodule

// File: rtl/cpuirq_pending_chk.sv
module cpuirq_pending_chk
   import cpuirq_pkg::*;
#(
   parameter int unsigned LVL_N = 16,
   localparam int unsigned DW = 2 * LVL_N
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [DW-1:0]     acc_wdata,
   input logic [DW-1:0]     acc_rdata,
   input logic [LVL_N-1:0]  hard_lvl,
   input logic              timer_req,
   input logic              master_dis,
   input logic [LVL_N-1:0]  lvl_out,
   input logic [DW-1:0]     pend_view
);

   localparam logic [63:0] SOFT64 = soft_mask(LVL_N);
   localparam logic [DW-1:0] SOFT = SOFT64[DW-1:0];

   assert_lvl0_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_out[0] == 1'b0);

   assert_rd_other_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write && acc_addr != 2'd0) |-> acc_rdata == '0);

   assert_set_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && acc_addr == 2'd2) |=>
      ((pend_view & SOFT & $past(acc_wdata)) == (SOFT & $past(acc_wdata))));

   assert_clear_soft_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && acc_addr == 2'd1) |=>
      ((pend_view[DW-1:LVL_N+1] & $past(acc_wdata[DW-1:LVL_N+1])) == '0));

   assert_timer_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !hard_lvl[LVL_N-2] |=> pend_view[LVL_N-2] == $past(timer_req));

   assert_soft_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_out[LVL_N-1:1] & pend_view[DW-1:LVL_N+1]) == pend_view[DW-1:LVL_N+1]);

   assert_mdis_timer_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_out[LVL_N-2] |->
      (pend_view[DW-2] || $past(hard_lvl[LVL_N-2]) || !$past(master_dis)));

   assert_hard_show_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend_view[LVL_N-1:1] & $past(hard_lvl[LVL_N-1:1]))
                == $past(hard_lvl[LVL_N-1:1])));

endmodule

bind cpuirq_pending_reg cpuirq_pending_chk #(.LVL_N(LVL_N)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_valid  (acc_valid),
   .acc_write  (acc_write),
   .acc_addr   (acc_addr),
   .acc_wdata  (acc_wdata),
   .acc_rdata  (acc_rdata),
   .hard_lvl   (hard_lvl),
   .timer_req  (timer_req),
   .master_dis (master_dis),
   .lvl_out    (lvl_out),
   .pend_view  (pend_view)
);

// File: tb/tb_cpuirq_pending_reg.sv
module tb_cpuirq_pending_reg;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [1:0]  acc_addr = '0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;
   logic [15:0] hard_lvl = '0;
   logic        timer_req = 1'b0;
   logic        l15_req = 1'b0;
   logic        master_dis = 1'b0;
   logic [15:0] lvl_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   cpuirq_pending_reg dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .hard_lvl(hard_lvl), .timer_req(timer_req), .l15_req(l15_req),
      .master_dis(master_dis), .lvl_out(lvl_out)
   );

   typedef struct packed {
      logic        wr;
      logic [1:0]  addr;
      logic [31:0] wdata;
      logic [15:0] hard;
      logic        tmr;
      logic        l15;
      logic        mdis;
      logic [31:0] exp_pend;
      logic [15:0] exp_lvl;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 2'd2, 32'hFFFF_FFFF, 16'h0000, 1'b0, 1'b0, 1'b0, 32'hFFFE_0000, 16'hFFFE}, // R4 R6
      '{1'b1, 2'd1, 32'h5555_5555, 16'h0000, 1'b0, 1'b0, 1'b0, 32'hAAAA_0000, 16'hAAAA}, // R3 R6
      '{1'b1, 2'd1, 32'hFFFF_FFFF, 16'h0000, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 16'h0000}, // R3
      '{1'b0, 2'd0, 32'h0000_0000, 16'h0000, 1'b1, 1'b0, 1'b0, 32'h0000_4000, 16'h4000}, // R5 R7
      '{1'b0, 2'd0, 32'h0000_0000, 16'h0000, 1'b1, 1'b0, 1'b1, 32'h0000_4000, 16'h0000}, // R7
      '{1'b0, 2'd0, 32'h0000_0000, 16'h0000, 1'b0, 1'b1, 1'b0, 32'h0000_8000, 16'h8000}, // R5
      '{1'b1, 2'd1, 32'h0000_C000, 16'h0000, 1'b1, 1'b1, 1'b0, 32'h0000_4000, 16'h4000}, // R3
      '{1'b1, 2'd2, 32'h0001_FFFF, 16'h0000, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 16'h0000}, // R4
      '{1'b0, 2'd0, 32'h0000_0000, 16'hA5A5, 1'b0, 1'b0, 1'b0, 32'h0000_A5A4, 16'hA5A4}, // R8 R9
      '{1'b0, 2'd0, 32'h0000_0000, 16'h0002, 1'b0, 1'b0, 1'b1, 32'h0000_0002, 16'h0002}, // R8
      '{1'b1, 2'd0, 32'hFFFF_FFFF, 16'h0000, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 16'h0000}, // R11
      '{1'b1, 2'd3, 32'hFFFF_FFFF, 16'h0000, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 16'h0000}, // R11
      '{1'b0, 2'd0, 32'h0000_0000, 16'h4000, 1'b1, 1'b0, 1'b1, 32'h0000_4000, 16'h4000}, // R7 R8
      '{1'b0, 2'd0, 32'h0000_0000, 16'h0000, 1'b0, 1'b1, 1'b0, 32'h0000_8000, 16'h8000}  // R5
   };

   function automatic string vec_req(input int i);
      case (i)
         0: return "R4";   1: return "R3";   2: return "R3";   3: return "R5";
         4: return "R7";   5: return "R5";   6: return "R3";   7: return "R4";
         8: return "R8";   9: return "R8";  10: return "R11"; 11: return "R11";
         12: return "R7";  default: return "R5";
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   // Called just after a falling edge: combinational read of one offset.
   task automatic read_at(input logic [1:0] a, output logic [31:0] d);
      acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
      #1 d = acc_rdata;
      acc_valid = 1'b0;
   endtask

   task automatic write_word(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = '0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] rd;

      // R1: state during and right after reset
      repeat (3) @(negedge clk);
      read_at(2'd0, rd);
      check("R1", "pend in reset", rd, 32'h0);
      check("R1", "lvl in reset", {16'h0, lvl_out}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      read_at(2'd0, rd);
      check("R1", "pend after reset", rd, 32'h0);
      check("R1", "lvl after reset", {16'h0, lvl_out}, 32'h0);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         hard_lvl = VEC[i].hard; timer_req = VEC[i].tmr;
         l15_req = VEC[i].l15; master_dis = VEC[i].mdis;
         if (VEC[i].wr) begin
            acc_valid = 1'b1; acc_write = 1'b1;
            acc_addr = VEC[i].addr; acc_wdata = VEC[i].wdata;
         end
         @(negedge clk);
         acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = '0;
         read_at(2'd0, rd);
         check(vec_req(i), $sformatf("vector %0d pend", i), rd, VEC[i].exp_pend);
         check(vec_req(i), $sformatf("vector %0d lvl", i), {16'h0, lvl_out},
               {16'h0, VEC[i].exp_lvl});
         check("R9", $sformatf("vector %0d lvl bit0", i), {31'h0, lvl_out[0]}, 32'h0);
      end

      // Return to a quiet state
      @(negedge clk);
      hard_lvl = '0; timer_req = 1'b0; l15_req = 1'b0; master_dis = 1'b0;
      @(negedge clk);

      // R2: readback by offset
      write_word(2'd2, 32'h0002_0000);
      read_at(2'd0, rd);
      check("R2", "offset 0 read", rd, 32'h0002_0000);
      read_at(2'd1, rd);
      check("R2", "offset 1 read", rd, 32'h0);
      read_at(2'd2, rd);
      check("R2", "offset 2 read", rd, 32'h0);
      read_at(2'd3, rd);
      check("R2", "offset 3 read", rd, 32'h0);
      #1 check("R2", "idle rdata", acc_rdata, 32'h0);
      check("R6", "soft bit 17 to level 1", {16'h0, lvl_out}, 32'h0000_0002);

      // R10: output waits for the clock edge
      @(negedge clk);
      timer_req = 1'b1;
      #1 check("R10", "lvl before edge", {16'h0, lvl_out}, 32'h0000_0002);
      @(negedge clk);
      check("R10", "lvl after edge", {16'h0, lvl_out}, 32'h0000_4002);
      acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 2'd1; acc_wdata = 32'h0002_0000;
      #1 check("R10", "lvl before write edge", {16'h0, lvl_out}, 32'h0000_4002);
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = '0;
      check("R10", "lvl after write edge", {16'h0, lvl_out}, 32'h0000_4000);

      // R1: reset in mid-run clears everything
      write_word(2'd2, 32'hF000_0000);
      @(negedge clk);
      rst_n = 1'b0; timer_req = 1'b0;
      @(negedge clk);
      read_at(2'd0, rd);
      check("R1", "pend after mid-run reset", rd, 32'h0);
      check("R1", "lvl after mid-run reset", {16'h0, lvl_out}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule